// File: doc/BRIEF.md
# DMA buffer pointer restart controller

This block keeps the buffer position of a single DMA channel. It holds two register pairs. The initial pair (start address and frame count) describes the buffer. The current pair (next address and frames still to go) tracks progress through it. Each frame-complete strobe from the transfer engine moves the current pair forward by one frame. When the last frame is done, the block either stops (one-shot) or starts the buffer again from the initial pair (circular).

The channel counts as enabled only when the global unit enable is 1 and the channel's two-bit enable field holds 01 or 10. At each rising edge of that enable, a mode bit picks the start point. With the mode bit at 1 the channel resumes from the current pair. With it at 0 the current pair is reloaded from the initial pair. Reset clears all four registers to zero. Software must therefore either make the first enable a reload, or copy the initial values into the current registers before it resumes. All four registers can be written through a shared data bus and are always visible on the outputs.

Top module: `buf_ptr_ctrl`

## Requirements
- R1: After reset, init_addr, init_cnt, cur_addr and cur_cnt are 0, and active and buf_end are 0.
- R2: A write strobe (wr_init_addr, wr_init_cnt, wr_cur_addr, wr_cur_cnt) loads wdata into its register on that clock edge; counts take the low CNT_W bits. Each value is visible on its output from the next cycle.
- R3: On a rising edge of the effective enable with resume_mode = 0, the current address and count are loaded from the initial address and count.
- R4: On a rising edge of the effective enable with resume_mode = 1, the current address and count keep their values.
- R5: While active, each accepted frame_done pulse adds FRAME_BYTES to cur_addr and subtracts 1 from cur_cnt in the same update. A frame_done in the cycle the enable rises is ignored.
- R6: In one-shot mode (circular = 0), the frame that brings cur_cnt from 1 to 0 leaves cur_addr one frame past the last frame. The same frame clears active and raises buf_end for one cycle. Later frame_done pulses change nothing until the next enable.
- R7: In circular mode (circular = 1), the frame that would bring cur_cnt to 0 instead reloads the initial address and count, whatever resume_mode holds. active stays 1 and buf_end pulses for one cycle.
- R8: A current-register write in the same cycle as frame_done wins, and that frame is dropped. Writing 0 to cur_cnt clears active.
- R9: The effective enable is unit_en AND (chan_en is 2'b01 or 2'b10). chan_en of 00 or 11 disables the channel. A rise caused by unit_en alone is treated like one caused by chan_en. active clears in the cycle after the effective enable drops.
- R10: After an enable edge, active is 1 exactly when the resulting cur_cnt is nonzero. A resume with cur_cnt = 0 leaves the channel idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_en | input | 1 | Global enable for the transfer unit |
| chan_en | input | 2 | Channel enable field; 01 or 10 enables the channel |
| resume_mode | input | 1 | 1: resume from current values on enable; 0: reload initial values |
| circular | input | 1 | 1: circular buffer; 0: one-shot |
| wr_init_addr | input | 1 | Write strobe for the initial address |
| wr_init_cnt | input | 1 | Write strobe for the initial frame count |
| wr_cur_addr | input | 1 | Write strobe for the current address |
| wr_cur_cnt | input | 1 | Write strobe for the current frame count |
| wdata | input | ADDR_W | Write data shared by all strobes |
| frame_done | input | 1 | Single-cycle frame-complete strobe |
| init_addr | output | ADDR_W | Initial address |
| init_cnt | output | CNT_W | Initial frame count |
| cur_addr | output | ADDR_W | Current address |
| cur_cnt | output | CNT_W | Frames remaining |
| active | output | 1 | Channel is running and accepts frames |
| buf_end | output | 1 | One-cycle pulse at the end of the buffer |

## Verification
The properties assume that every input is synchronous to clk and is sampled once per edge. They also assume that reset is held at the start of time, so the enable history they rebuild from unit_en and chan_en agrees with the block's own edge detector. The stimulus changes inputs only on the falling edge and applies one operation per cycle. The one deliberate exception is a frame strobe paired with a current-address write, which is the collision the priority rule is about. Enable rises are driven from both unit_en and chan_en, so each path into the rise detector is exercised within those assumptions.

// File: rtl/buf_ptr_ctrl.sv
module buf_ptr_ctrl #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int FRAME_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_en,
  input  logic [1:0]        chan_en,
  input  logic              resume_mode,
  input  logic              circular,
  input  logic              wr_init_addr,
  input  logic              wr_init_cnt,
  input  logic              wr_cur_addr,
  input  logic              wr_cur_cnt,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              frame_done,
  output logic [ADDR_W-1:0] init_addr,
  output logic [CNT_W-1:0]  init_cnt,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic              active,
  output logic              buf_end
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(FRAME_BYTES);
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  logic              en_eff, en_q, rise, cur_wr, take, last, wrap;
  logic [ADDR_W-1:0] ld_addr, fin_addr;
  logic [CNT_W-1:0]  ld_cnt, fin_cnt, wcnt;

  assign en_eff = unit_en & (chan_en[0] ^ chan_en[1]);
  assign rise   = en_eff & ~en_q;
  assign cur_wr = wr_cur_addr | wr_cur_cnt;
  assign wcnt   = wdata[CNT_W-1:0];

  assign take = frame_done & active & en_eff & ~rise & ~cur_wr;
  assign last = take & (cur_cnt == ONE);
  assign wrap = last & circular;

  assign ld_addr  = resume_mode ? cur_addr : init_addr;
  assign ld_cnt   = resume_mode ? cur_cnt  : init_cnt;
  assign fin_addr = wr_cur_addr ? wdata : ld_addr;
  assign fin_cnt  = wr_cur_cnt  ? wcnt  : ld_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      init_addr <= '0;
      init_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      active    <= 1'b0;
      buf_end   <= 1'b0;
    end else begin
      en_q    <= en_eff;
      buf_end <= last;
      if (wr_init_addr) init_addr <= wdata;
      if (wr_init_cnt)  init_cnt  <= wcnt;
      if (rise) begin
        cur_addr <= fin_addr;
        cur_cnt  <= fin_cnt;
        active   <= (fin_cnt != '0);
      end else if (cur_wr) begin
        if (wr_cur_addr) cur_addr <= wdata;
        if (wr_cur_cnt)  cur_cnt  <= wcnt;
        active <= active & en_eff & ~(wr_cur_cnt & (wcnt == '0));
      end else if (!en_eff) begin
        active <= 1'b0;
      end else if (wrap) begin
        cur_addr <= init_addr;
        cur_cnt  <= init_cnt;
        active   <= (init_cnt != '0);
      end else if (take) begin
        cur_addr <= cur_addr + STEP;
        cur_cnt  <= cur_cnt - ONE;
        if (last) active <= 1'b0;
      end
    end
  end

endmodule

module buf_ptr_ctrl_chk #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int FRAME_BYTES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              unit_en,
  input logic [1:0]        chan_en,
  input logic              resume_mode,
  input logic              circular,
  input logic              wr_cur_addr,
  input logic              wr_cur_cnt,
  input logic [ADDR_W-1:0] wdata,
  input logic              frame_done,
  input logic [ADDR_W-1:0] init_addr,
  input logic [CNT_W-1:0]  init_cnt,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [CNT_W-1:0]  cur_cnt,
  input logic              active,
  input logic              buf_end
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(FRAME_BYTES);

  logic on, nowr;
  assign on   = unit_en & (chan_en[0] ^ chan_en[1]);
  assign nowr = ~wr_cur_addr & ~wr_cur_cnt;

  // R10
  active_has_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cur_cnt != '0);

  // R6
  end_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_end |-> $past(frame_done));

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !$past(on) && !resume_mode && nowr)
      |=> (cur_addr == $past(init_addr)) && (cur_cnt == $past(init_cnt)));

  // R4
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !$past(on) && resume_mode && nowr)
      |=> $stable(cur_addr) && $stable(cur_cnt));

  // R5
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && active && on && nowr && cur_cnt > CNT_W'(1))
      |=> (cur_addr == $past(cur_addr) + STEP) && (cur_cnt == $past(cur_cnt) - CNT_W'(1)));

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && active && on && nowr && !circular && cur_cnt == CNT_W'(1))
      |=> (cur_cnt == '0) && !active && buf_end && (cur_addr == $past(cur_addr) + STEP));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && active && on && nowr && circular && cur_cnt == CNT_W'(1))
      |=> (cur_addr == $past(init_addr)) && buf_end);

  // R8
  sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cur_addr |=> cur_addr == $past(wdata));

  // R9
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> !active);
endmodule

bind buf_ptr_ctrl buf_ptr_ctrl_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FRAME_BYTES(FRAME_BYTES)
) i_chk (
  .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .chan_en(chan_en),
  .resume_mode(resume_mode), .circular(circular),
  .wr_cur_addr(wr_cur_addr), .wr_cur_cnt(wr_cur_cnt), .wdata(wdata),
  .frame_done(frame_done), .init_addr(init_addr), .init_cnt(init_cnt),
  .cur_addr(cur_addr), .cur_cnt(cur_cnt), .active(active), .buf_end(buf_end)
);

// File: tb/test_buf_ptr_ctrl.sv
module test_buf_ptr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        unit_en = 1'b0;
  logic [1:0]  chan_en = 2'b00;
  logic        resume_mode = 1'b0, circular = 1'b0;
  logic        wr_init_addr = 1'b0, wr_init_cnt = 1'b0, wr_cur_addr = 1'b0, wr_cur_cnt = 1'b0;
  logic [31:0] wdata = '0;
  logic        frame_done = 1'b0;
  logic [31:0] init_addr, cur_addr;
  logic [15:0] init_cnt, cur_cnt;
  logic        active, buf_end;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  buf_ptr_ctrl i_buf_ptr_ctrl (
    .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .chan_en(chan_en),
    .resume_mode(resume_mode), .circular(circular),
    .wr_init_addr(wr_init_addr), .wr_init_cnt(wr_init_cnt),
    .wr_cur_addr(wr_cur_addr), .wr_cur_cnt(wr_cur_cnt), .wdata(wdata),
    .frame_done(frame_done), .init_addr(init_addr), .init_cnt(init_cnt),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .active(active), .buf_end(buf_end)
  );

  // op codes
  localparam int IDLE = 0, WIA = 1, WIC = 2, WCA = 3, WCC = 4, FRM = 5, ON = 6, OFF = 7,
                 RES = 8, RLD = 9, CIRC = 10, ONESH = 11, FRMW = 12;

  // {op, data, exp cur_addr, exp cur_cnt, exp active, exp buf_end}
  localparam logic [85:0] VEC [0:32] = '{
    {4'd1,  32'h1000, 32'h0000, 16'd0, 1'b0, 1'b0},
    {4'd2,  32'h0003, 32'h0000, 16'd0, 1'b0, 1'b0},
    {4'd9,  32'h0,    32'h0000, 16'd0, 1'b0, 1'b0},
    {4'd11, 32'h0,    32'h0000, 16'd0, 1'b0, 1'b0},
    {4'd6,  32'h0,    32'h1000, 16'd3, 1'b1, 1'b0},
    {4'd5,  32'h0,    32'h1010, 16'd2, 1'b1, 1'b0},
    {4'd5,  32'h0,    32'h1020, 16'd1, 1'b1, 1'b0},
    {4'd5,  32'h0,    32'h1030, 16'd0, 1'b0, 1'b1},
    {4'd5,  32'h0,    32'h1030, 16'd0, 1'b0, 1'b0},
    {4'd7,  32'h0,    32'h1030, 16'd0, 1'b0, 1'b0},
    {4'd8,  32'h0,    32'h1030, 16'd0, 1'b0, 1'b0},
    {4'd6,  32'h0,    32'h1030, 16'd0, 1'b0, 1'b0},
    {4'd7,  32'h0,    32'h1030, 16'd0, 1'b0, 1'b0},
    {4'd3,  32'h2000, 32'h2000, 16'd0, 1'b0, 1'b0},
    {4'd4,  32'h0002, 32'h2000, 16'd2, 1'b0, 1'b0},
    {4'd6,  32'h0,    32'h2000, 16'd2, 1'b1, 1'b0},
    {4'd5,  32'h0,    32'h2010, 16'd1, 1'b1, 1'b0},
    {4'd12, 32'h3000, 32'h3000, 16'd1, 1'b1, 1'b0},
    {4'd7,  32'h0,    32'h3000, 16'd1, 1'b0, 1'b0},
    {4'd6,  32'h0,    32'h3000, 16'd1, 1'b1, 1'b0},
    {4'd5,  32'h0,    32'h3010, 16'd0, 1'b0, 1'b1},
    {4'd7,  32'h0,    32'h3010, 16'd0, 1'b0, 1'b0},
    {4'd10, 32'h0,    32'h3010, 16'd0, 1'b0, 1'b0},
    {4'd9,  32'h0,    32'h3010, 16'd0, 1'b0, 1'b0},
    {4'd6,  32'h0,    32'h1000, 16'd3, 1'b1, 1'b0},
    {4'd5,  32'h0,    32'h1010, 16'd2, 1'b1, 1'b0},
    {4'd5,  32'h0,    32'h1020, 16'd1, 1'b1, 1'b0},
    {4'd5,  32'h0,    32'h1000, 16'd3, 1'b1, 1'b1},
    {4'd8,  32'h0,    32'h1000, 16'd3, 1'b1, 1'b0},
    {4'd5,  32'h0,    32'h1010, 16'd2, 1'b1, 1'b0},
    {4'd5,  32'h0,    32'h1020, 16'd1, 1'b1, 1'b0},
    {4'd5,  32'h0,    32'h1000, 16'd3, 1'b1, 1'b1},
    {4'd7,  32'h0,    32'h1000, 16'd3, 1'b0, 1'b0}
  };

  // requirement covered by each row
  localparam int REQ [0:32] = '{2, 2, 3, 6, 3, 5, 5, 6, 6, 9, 4, 10, 9, 2, 2, 4, 5,
                                8, 9, 4, 6, 9, 7, 3, 3, 5, 5, 7, 7, 7, 7, 7, 9};

  function automatic string tag(int n);
    case (n)
      1: return "R1";   2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";   6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_init_addr = 1'b0; wr_init_cnt = 1'b0; wr_cur_addr = 1'b0; wr_cur_cnt = 1'b0;
    frame_done = 1'b0;
  endtask

  task automatic apply(int op, logic [31:0] d);
    wdata = d;
    case (op)
      WIA:   wr_init_addr = 1'b1;
      WIC:   wr_init_cnt = 1'b1;
      WCA:   wr_cur_addr = 1'b1;
      WCC:   wr_cur_cnt = 1'b1;
      FRM:   frame_done = 1'b1;
      ON:    begin unit_en = 1'b1; chan_en = 2'b01; end
      OFF:   chan_en = 2'b00;
      RES:   resume_mode = 1'b1;
      RLD:   resume_mode = 1'b0;
      CIRC:  circular = 1'b1;
      ONESH: circular = 1'b0;
      FRMW:  begin frame_done = 1'b1; wr_cur_addr = 1'b1; end
      default: ;
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "init_addr", init_addr, 32'h0);
    check("R1", "init_cnt", 32'(init_cnt), 32'h0);
    check("R1", "cur_addr", cur_addr, 32'h0);
    check("R1", "cur_cnt", 32'(cur_cnt), 32'h0);
    check("R1", "active", 32'(active), 32'h0);
    check("R1", "buf_end", 32'(buf_end), 32'h0);

    for (int i = 0; i < 33; i++) begin
      apply(int'(VEC[i][85:82]), VEC[i][81:50]);
      step();
      check(tag(REQ[i]), $sformatf("row %0d cur_addr", i), cur_addr, VEC[i][49:18]);
      check(tag(REQ[i]), $sformatf("row %0d cur_cnt", i), 32'(cur_cnt), 32'(VEC[i][17:2]));
      check(tag(REQ[i]), $sformatf("row %0d active", i), 32'(active), 32'(VEC[i][1]));
      check(tag(REQ[i]), $sformatf("row %0d buf_end", i), 32'(buf_end), 32'(VEC[i][0]));
    end

    // R2 initial registers read back
    check("R2", "init_addr", init_addr, 32'h1000);
    check("R2", "init_cnt", 32'(init_cnt), 32'h3);

    // R9 chan_en = 11 does not enable
    resume_mode = 1'b0;
    apply(WCA, 32'h5000); step();
    chan_en = 2'b11; step();
    check("R9", "cur_addr with chan 11", cur_addr, 32'h5000);
    check("R9", "active with chan 11", 32'(active), 32'h0);
    // R9 field 10 without unit_en stays off
    unit_en = 1'b0; chan_en = 2'b10; step();
    check("R9", "active unit off", 32'(active), 32'h0);
    check("R9", "cur_addr unit off", cur_addr, 32'h5000);
    // R9 R3 rise through unit_en reloads
    unit_en = 1'b1; step();
    check("R9", "cur_addr unit rise", cur_addr, 32'h1000);
    check("R3", "cur_cnt unit rise", 32'(cur_cnt), 32'h3);
    check("R9", "active unit rise", 32'(active), 32'h1);
    // R8 writing zero count stops the channel
    apply(WCC, 32'h0); step();
    check("R8", "cur_cnt zero write", 32'(cur_cnt), 32'h0);
    check("R8", "active after zero write", 32'(active), 32'h0);
    // R6 idle channel ignores frames
    apply(FRM, 32'h0); step();
    check("R6", "cur_addr idle frame", cur_addr, 32'h1000);
    check("R6", "buf_end idle frame", 32'(buf_end), 32'h0);
    // R9 drop of unit_en clears active
    apply(WCC, 32'h2); step();
    check("R8", "active after count write", 32'(active), 32'h0);
    unit_en = 1'b0; chan_en = 2'b00; step();
    apply(ON, 32'h0); step();
    check("R3", "reload rise", 32'(cur_cnt), 32'h3);
    unit_en = 1'b0; step();
    check("R9", "active after unit drop", 32'(active), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule